// File: doc/BRIEF.md
# Dual-Channel H-Bridge PWM Timer

This block drives one H-bridge motor from two edge-aligned PWM channels. A single down-counter, advanced by a prescaled tick from one of three selectable timebases, sets the length of each PWM cycle. Each channel has its own compare value. Both channel waveforms go high when the counter reloads. Each one falls when the count drops below that channel's compare value.

A drive-mode field decides what each of the two motor pins shows. A pin can carry its channel's PWM waveform or a fixed level. The available modes are coast, forward, backward, brake and dual PWM. The block is set up through a synchronous write port with one address per setting.

Top module: `pwm_hbridge`

## Requirements
- R1: While `rst_ni` is low, both pins are low and the counter is stopped. After reset every setting is zero: coast mode, timer disabled, no source selected.
- R2: The counter counts down one step per prescaled tick. After 0 it reloads with period−1, so one PWM cycle is `period` ticks long. A period of 0 behaves as a period of 1.
- R3: Each channel's PWM is high while the count is greater than or equal to its compare value. It is also high on the reload count period−1. A compare of 0 therefore gives a channel that is high for the whole cycle.
- R4: A compare value of period−1 or larger makes the channel high only on the reload count, which is one tick per cycle.
- R5: A tick occurs every (prescale+1) qualifying source pulses. Prescale is the low 8 bits of address 1.
- R6: The source code at address 2 selects the timebase. Code 2 counts `lf_tick_i` pulses, code 4 counts `mf_tick_i` pulses, and code 8 counts every clock. With any other code the counter and both pins hold their state.
- R7: The mode at address 5 maps the pins as follows. Code 0 is coast: both pins low. Code 1 is forward: pin 0 carries PWM 0 and pin 1 is high. Code 2 is backward: pin 0 is high and pin 1 carries PWM 1. Code 3 is brake: both pins high. Code 4 is dual PWM: each pin carries its own channel. Codes 5 to 7 act as coast. The pins are registered, so they follow the internal state one clock later.
- R8: Period (address 0) and the compares (address 3 for channel 0, address 4 for channel 1) are written into shadow copies. The counter uses these copies only at the next reload or at start-up.
- R9: Bit 0 of address 6 is the enable. While it is clear, the counter and the prescaler are held at zero and both PWM waveforms are low. The clock after it is set, counting starts at period−1 with both PWM waveforms high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, which is also the fastest timebase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lf_tick_i | input | 1 | Low-frequency timebase pulse, one clock wide |
| mf_tick_i | input | 1 | Mid-frequency timebase pulse, one clock wide |
| wr_en_i | input | 1 | Write strobe for the setting port |
| wr_addr_i | input | 3 | Setting address (0 to 6) |
| wr_data_i | input | CNT_W | Write data |
| pin_o | output | 2 | Motor pins; bit 0 is pin 0, bit 1 is pin 1 |

## Verification
The case that is hardest to reach is a period or compare write that lands in the middle of a cycle while the prescaler is part-way through a count and the selected timebase is pulsing irregularly. The shadow copies must hold off the change until the next reload, and the counter must not run past the old period. Random stimulus with a fixed seed writes every setting at unpredictable cycles and pulses both slow timebases at random. A cycle-level model in the bench predicts each pin on every clock. Directed sections count high cycles over aligned-free windows to pin down duty, prescaling and the compare corner cases.

// File: rtl/pwm_hb_pkg.sv
package pwm_hb_pkg;
  typedef enum logic [2:0] {
    MODE_COAST = 3'd0,
    MODE_FWD   = 3'd1,
    MODE_BWD   = 3'd2,
    MODE_BRAKE = 3'd3,
    MODE_DUAL  = 3'd4
  } drive_mode_e;

  localparam logic [2:0] ADDR_PERIOD = 3'd0;
  localparam logic [2:0] ADDR_PSC    = 3'd1;
  localparam logic [2:0] ADDR_SRC    = 3'd2;
  localparam logic [2:0] ADDR_CMP0   = 3'd3;
  localparam logic [2:0] ADDR_CMP1   = 3'd4;
  localparam logic [2:0] ADDR_MODE   = 3'd5;
  localparam logic [2:0] ADDR_EN     = 3'd6;

  localparam logic [3:0] SRC_LF  = 4'd2;
  localparam logic [3:0] SRC_MF  = 4'd4;
  localparam logic [3:0] SRC_BUS = 4'd8;
endpackage

// File: rtl/pwm_hb_tick.sv
module pwm_hb_tick #(
  parameter int PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            lf_tick_i,
  input  logic            mf_tick_i,
  input  logic [3:0]      src_i,
  input  logic [PS_W-1:0] psc_i,
  output logic            hit_o,
  output logic            tick_o
);
  import pwm_hb_pkg::*;

  logic [PS_W-1:0] pre_q;
  logic            wrap;

  always_comb begin
    unique case (src_i)
      SRC_LF:  hit_o = lf_tick_i;
      SRC_MF:  hit_o = mf_tick_i;
      SRC_BUS: hit_o = 1'b1;
      default: hit_o = 1'b0;
    endcase
  end

  // >= so that lowering the prescale mid-count cannot overshoot
  assign wrap   = (pre_q >= psc_i);
  assign tick_o = run_i && hit_o && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (!run_i)         pre_q <= '0;
    else if (hit_o && wrap)  pre_q <= '0;
    else if (hit_o)          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_hb_counter.sv
module pwm_hb_counter #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        tick_i,
  input  logic [CNT_W-1:0]            per_sh_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  cmp_sh_i,
  output logic                        run_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [CNT_W-1:0]            per_m1_o,
  output logic [N_CH-1:0]             pwm_o
);
  logic                       run_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [CNT_W-1:0]           per_act_q;
  logic [N_CH-1:0][CNT_W-1:0] cmp_act_q;
  logic [CNT_W-1:0]           sh_m1;

  assign sh_m1    = (per_sh_i  == '0) ? '0 : per_sh_i  - 1'b1;
  assign per_m1_o = (per_act_q == '0) ? '0 : per_act_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      per_act_q <= '0;
      cmp_act_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || (tick_i && cnt_q == '0)) begin
      run_q     <= 1'b1;
      cnt_q     <= sh_m1;
      per_act_q <= per_sh_i;
      cmp_act_q <= cmp_sh_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign pwm_o[g] = run_q && ((cnt_q >= cmp_act_q[g]) || (cnt_q == per_m1_o));
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_hb_pinmux.sv
module pwm_hb_pinmux (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic [1:0] pwm_i,
  output logic [1:0] pin_o
);
  import pwm_hb_pkg::*;

  logic [1:0] pin_d;

  always_comb begin
    unique case (mode_i)
      MODE_FWD:   pin_d = {1'b1, pwm_i[0]};
      MODE_BWD:   pin_d = {pwm_i[1], 1'b1};
      MODE_BRAKE: pin_d = 2'b11;
      MODE_DUAL:  pin_d = pwm_i;
      default:    pin_d = 2'b00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 2'b00;
    else         pin_o <= pin_d;
  end
endmodule

// File: rtl/pwm_hbridge.sv
module pwm_hbridge #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lf_tick_i,
  input  logic             mf_tick_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [1:0]       pin_o
);
  import pwm_hb_pkg::*;

  localparam int N_CH = 2;

  logic [CNT_W-1:0]           per_q;
  logic [PS_W-1:0]            psc_q;
  logic [3:0]                 src_q;
  logic [N_CH-1:0][CNT_W-1:0] cmp_q;
  logic [2:0]                 mode_q;
  logic                       en_q;

  logic                       run, hit, tick;
  logic [CNT_W-1:0]           cnt, per_m1;
  logic [N_CH-1:0]            pwm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      psc_q  <= '0;
      src_q  <= '0;
      cmp_q  <= '0;
      mode_q <= MODE_COAST;
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PERIOD: per_q    <= wr_data_i;
        ADDR_PSC:    psc_q    <= wr_data_i[PS_W-1:0];
        ADDR_SRC:    src_q    <= wr_data_i[3:0];
        ADDR_CMP0:   cmp_q[0] <= wr_data_i;
        ADDR_CMP1:   cmp_q[1] <= wr_data_i;
        ADDR_MODE:   mode_q   <= wr_data_i[2:0];
        ADDR_EN:     en_q     <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  pwm_hb_tick #(.PS_W(PS_W)) i_tick (
    .clk_i, .rst_ni,
    .run_i     (run),
    .lf_tick_i,
    .mf_tick_i,
    .src_i     (src_q),
    .psc_i     (psc_q),
    .hit_o     (hit),
    .tick_o    (tick)
  );

  pwm_hb_counter #(.CNT_W(CNT_W), .N_CH(N_CH)) i_cnt (
    .clk_i, .rst_ni,
    .en_i      (en_q),
    .tick_i    (tick),
    .per_sh_i  (per_q),
    .cmp_sh_i  (cmp_q),
    .run_o     (run),
    .cnt_o     (cnt),
    .per_m1_o  (per_m1),
    .pwm_o     (pwm)
  );

  pwm_hb_pinmux i_mux (
    .clk_i, .rst_ni,
    .mode_i    (mode_q),
    .pwm_i     (pwm),
    .pin_o     (pin_o)
  );
endmodule

// File: rtl/pwm_hb_chk.sv
module pwm_hb_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             run_i,
  input logic             hit_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] per_m1_i,
  input logic [2:0]       mode_i,
  input logic [1:0]       pin_i
);
  import pwm_hb_pkg::*;

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && run_i && tick_i && cnt_i != '0 |=> cnt_i == CNT_W'($past(cnt_i) - 1'b1)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_i <= per_m1_i); // R2
  AST_NO_SRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && run_i && !hit_i |=> $stable(cnt_i)); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !run_i && cnt_i == '0); // R9
  AST_BRAKE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_BRAKE |=> pin_i == 2'b11); // R7
  AST_COAST_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_COAST |=> pin_i == 2'b00); // R7
  AST_RELOAD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && cnt_i == per_m1_i && mode_i == MODE_DUAL |=> pin_i == 2'b11); // R3
endmodule

bind pwm_hbridge pwm_hb_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_q),
  .run_i    (run),
  .hit_i    (hit),
  .tick_i   (tick),
  .cnt_i    (cnt),
  .per_m1_i (per_m1),
  .mode_i   (mode_q),
  .pin_i    (pin_o)
);

// File: tb/test_pwm_hbridge.sv
`timescale 1ns/1ps
module test_pwm_hbridge;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lf = 1'b0, mf = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   pin;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pwm_hbridge #(.CNT_W(W), .PS_W(8)) i_pwm_hbridge (
    .clk_i(clk), .rst_ni(rst_n), .lf_tick_i(lf), .mf_tick_i(mf),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pin_o(pin)
  );

  // reference model state
  logic [W-1:0] m_per, m_cmp0, m_cmp1, m_pa, m_ca0, m_ca1, m_cnt;
  logic [7:0]   m_ps, m_pre;
  logic [3:0]   m_src;
  logic [2:0]   m_mode;
  logic         m_en, m_run;
  logic [1:0]   m_pin;

  function automatic logic [W-1:0] eff_m1(logic [W-1:0] p);
    return (p == 0) ? '0 : p - 1'b1;
  endfunction

  function automatic logic [1:0] map_pins(logic [2:0] md, logic [1:0] pw);
    case (md)
      3'd1: return {1'b1, pw[0]};
      3'd2: return {pw[1], 1'b1};
      3'd3: return 2'b11;
      3'd4: return pw;
      default: return 2'b00;
    endcase
  endfunction

  task automatic model_reset();
    m_per = 0; m_cmp0 = 0; m_cmp1 = 0; m_pa = 0; m_ca0 = 0; m_ca1 = 0; m_cnt = 0;
    m_ps = 0; m_pre = 0; m_src = 0; m_mode = 0; m_en = 0; m_run = 0; m_pin = 0;
  endtask

  task automatic model_edge();
    logic hit, tk;
    logic [1:0] pw;
    logic [W-1:0] pm1;
    if (!rst_n) begin model_reset(); return; end
    pm1 = eff_m1(m_pa);
    pw[0] = m_run && (m_cnt >= m_ca0 || m_cnt == pm1);
    pw[1] = m_run && (m_cnt >= m_ca1 || m_cnt == pm1);
    hit = (m_src == 4'd2 && lf) || (m_src == 4'd4 && mf) || (m_src == 4'd8);
    tk = m_run && hit && (m_pre >= m_ps);
    m_pin = map_pins(m_mode, pw);
    if (!m_run || (hit && m_pre >= m_ps)) m_pre = 0;
    else if (hit) m_pre = m_pre + 1;
    if (!m_en) begin
      m_run = 0; m_cnt = 0;
    end else if (!m_run || (tk && m_cnt == 0)) begin
      m_run = 1; m_cnt = eff_m1(m_per); m_pa = m_per; m_ca0 = m_cmp0; m_ca1 = m_cmp1;
    end else if (tk) begin
      m_cnt = m_cnt - 1'b1;
    end
    if (wr_en) begin
      case (wr_addr)
        3'd0: m_per  = wr_data;
        3'd1: m_ps   = wr_data[7:0];
        3'd2: m_src  = wr_data[3:0];
        3'd3: m_cmp0 = wr_data;
        3'd4: m_cmp1 = wr_data;
        3'd5: m_mode = wr_data[2:0];
        3'd6: m_en   = wr_data[0];
        default: ;
      endcase
    end
  endtask

  task automatic check(string req, logic [1:0] got, logic [1:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s pin=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, pin, m_pin);
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d, string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(req);
    wr_en = 1'b0;
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic window(int n, string req, int e0, int e1);
    int c0 = 0, c1 = 0;
    for (int i = 0; i < n; i++) begin
      step(req);
      c0 += int'(pin[0]);
      c1 += int'(pin[1]);
    end
    vectors++;
    if (c0 != e0 || c1 != e1) begin
      fails++;
      $display("FAIL %s high counts=%0d/%0d expected=%0d/%0d", req, c0, c1, e0, e1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    // R1: reset holds pins low
    run(4, "R1");
    @(negedge clk); rst_n = 1'b1;
    run(3, "R1");

    // R3: period 5, cmp0 2 -> 3/5 high, cmp1 0 -> always high
    wr(3'd0, 16'd5, "R8"); wr(3'd3, 16'd2, "R8"); wr(3'd4, 16'd0, "R8");
    wr(3'd1, 16'd0, "R5"); wr(3'd2, 16'd8, "R6"); wr(3'd5, 16'd4, "R7");
    wr(3'd6, 16'd1, "R9");
    run(8, "R3");
    window(10, "R3", 6, 10);
    window(10, "R2", 6, 10);

    // R4: compares at/above period-1 -> one tick high per cycle
    wr(3'd3, 16'd9, "R4"); wr(3'd4, 16'd4, "R4");
    run(8, "R4");
    window(10, "R4", 2, 2);

    // R5: prescale 2 -> each tick three clocks
    wr(3'd1, 16'd2, "R5");
    run(20, "R5");
    window(30, "R5", 6, 6);
    wr(3'd1, 16'd0, "R5");

    // R2: period 0 acts as 1 -> always high
    wr(3'd0, 16'd0, "R2");
    run(10, "R2");
    window(8, "R2", 8, 8);

    // R6: unknown source freezes, slow sources count pulses
    wr(3'd0, 16'd6, "R6"); wr(3'd3, 16'd3, "R6"); wr(3'd4, 16'd1, "R6");
    run(9, "R6");
    wr(3'd2, 16'd5, "R6");
    run(20, "R6");
    wr(3'd2, 16'd2, "R6");
    for (int i = 0; i < 60; i++) begin lf = ($urandom % 3) == 0; step("R6"); end
    lf = 1'b0;
    wr(3'd2, 16'd4, "R6");
    for (int i = 0; i < 60; i++) begin mf = ($urandom % 2) == 0; step("R6"); end
    mf = 1'b0;
    wr(3'd2, 16'd8, "R6");

    // R7: every mode code
    for (int md = 0; md < 8; md++) begin
      wr(3'd5, W'(md), "R7");
      run(14, "R7");
    end
    wr(3'd5, 16'd4, "R7");

    // R8: mid-cycle period and compare change
    wr(3'd0, 16'd10, "R8"); run(3, "R8");
    wr(3'd3, 16'd7, "R8"); run(4, "R8");
    wr(3'd0, 16'd3, "R8"); wr(3'd4, 16'd2, "R8");
    run(30, "R8");

    // R9: disable drops PWM, re-enable restarts high
    wr(3'd6, 16'd0, "R9"); run(6, "R9");
    wr(3'd6, 16'd1, "R9"); run(12, "R9");
    wr(3'd6, 16'd0, "R9"); wr(3'd6, 16'd1, "R9"); run(6, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      lf = $urandom % 2; mf = $urandom % 2;
      if (($urandom % 6) == 0) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom % 8);
        case (wr_addr)
          3'd0, 3'd3, 3'd4: wr_data = W'($urandom % 14);
          3'd1:             wr_data = W'($urandom % 4);
          3'd2: begin
            case ($urandom % 5)
              0: wr_data = 16'd2; 1: wr_data = 16'd4; 2: wr_data = 16'd8;
              3: wr_data = 16'd0; default: wr_data = 16'd3;
            endcase
          end
          3'd6:             wr_data = W'(($urandom % 8) != 0);
          default:          wr_data = W'($urandom % 8);
        endcase
      end else wr_en = 1'b0;
      step("R8");
    end
    wr_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule